// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block holds the interrupt state of a small 8-bit processor core. Four hardware event sources feed it: timer 1, timer 0, a multi-input wakeup and an ADC. A fifth, software-raised request comes from the core when it executes its software-interrupt instruction. Each hardware source has a pending flag and an enable bit. All hardware requests are also gated by a global mask bit G. The software request ignores G.

The sequencer waits in `S_IDLE`. When a request is eligible and the core reports that its current instruction has completed, it takes the transition *accept* and runs a five-cycle entry: `S_PUSH_LO` writes the low byte of the return address to the stack, `S_PUSH_HI` writes the high byte, `S_MASK` clears G, `S_VECT` settles the vector, and `S_LOAD` drives the winning source's vector onto the program-counter load port. It then takes *done* back to `S_IDLE`. On a return strobe it takes the transition *return* from `S_IDLE`. It pops the high byte (`S_POP_HI`), then the low byte (`S_POP_LO`), and loads the restored address in `S_RLOAD`. After that it takes *done* back to `S_IDLE`. A return-with-mask restores G to 1 and a plain return leaves G alone. Pending flags are never cleared by the entry sequence, so software clears them.

Top module: `irq_sequencer`

## Requirements
- R1: Hardware pending flags use bit order 3 = timer 1, 2 = timer 0, 1 = wakeup, 0 = ADC. An event pulse sets its flag one cycle later and a clear pulse clears it. When a clear and an event arrive in the same cycle the flag stays set. Entry never clears a flag.
- R2: A hardware source is eligible only when its pending flag, its enable bit and G are all 1.
- R3: A software request is latched in `swi_pending` and is taken whatever the value of G. The latch drops when the request is accepted.
- R4: Entry starts only in a cycle where `instr_done` is 1 in `S_IDLE` with an eligible request. Without `instr_done` the block stays idle.
- R5: After acceptance in cycle k, `busy` is 1 for exactly cycles k+1 to k+5. The stack is written in cycle k+1 with the PC low byte and in cycle k+2 with the high byte.
- R6: G is 0 from cycle k+4 of an entry onward.
- R7: In cycle k+5 `pc_load` is 1 and `pc_out` equals 0xFF0 + 2 × rank. The ranks are: software 0, timer 1 1, timer 0 2, wakeup 3, ADC 4.
- R8: When several sources are eligible, the lowest rank of R7 wins.
- R9: A `reti_req` in cycle k pops in cycles k+1 (high byte) and k+2 (low byte), loads the restored PC in cycle k+3, and sets G to 1 from cycle k+4.
- R10: A `ret_req` restores the PC with the same timing as R9 and leaves G unchanged.
- R11: Requests that arrive during a sequence stay pending and are evaluated only in `S_IDLE`. With G cleared, hardware requests do not nest.
- R12: The pushed high byte holds PC bits 11:8 in its low nibble, with the upper nibble zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 4 | Hardware event pulses (bit order as in R1) |
| src_clr | input | 4 | Pending-flag clear pulses from software |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 4 | New enable bits |
| g_wr | input | 1 | Write strobe for G |
| g_wdata | input | 1 | New value of G |
| swi_req | input | 1 | Software-interrupt instruction executed |
| instr_done | input | 1 | Current instruction completes this cycle |
| ret_req | input | 1 | Plain return instruction |
| reti_req | input | 1 | Return-with-mask instruction |
| pc_in | input | 12 | Current program counter (return address) |
| stk_rdata | input | 8 | Byte read from the top of stack |
| stk_we | output | 1 | Push strobe |
| stk_re | output | 1 | Pop strobe |
| stk_wdata | output | 8 | Byte to push |
| pc_load | output | 1 | Load the program counter |
| pc_out | output | 12 | Value to load into the program counter |
| busy | output | 1 | Sequence active; the core stalls |
| pend_out | output | 4 | Hardware pending flags |
| en_out | output | 4 | Enable bits |
| g_out | output | 1 | Global mask bit G |
| swi_pending | output | 1 | Latched software request |

## Verification
An entry accepted at cycle k has a fixed schedule: the low push at k+1, the high push at k+2, G clear from k+4 and the vector load at k+5. A return issued at k loads the PC at k+3, and G changes at k+4. Pending flags are visible one cycle after their pulse. The driver tasks stamp each expected push and load with the cycle in which it is due. The monitor samples on the falling edge and compares both the value and that cycle, so an early or late result counts as a mismatch. Flag, mask and idle checks sample directly at the cycle the requirement names.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NHW  = 4;
    localparam int NSRC = NHW + 1;

    localparam int IDX_ADC = 0;
    localparam int IDX_WK  = 1;
    localparam int IDX_T0  = 2;
    localparam int IDX_T1  = 3;
    localparam int IDX_SWI = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_LO,
        S_PUSH_HI,
        S_MASK,
        S_VECT,
        S_LOAD,
        S_POP_HI,
        S_POP_LO,
        S_RLOAD
    } seq_state_t;
endpackage

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NHW-1:0] evt,
    input  logic [NHW-1:0] clr,
    input  logic           en_wr,
    input  logic [NHW-1:0] en_wdata,
    input  logic           g_wr,
    input  logic           g_wdata,
    input  logic           g_clr_seq,
    input  logic           g_set_seq,
    input  logic           swi_req,
    input  logic           swi_take,
    output logic [NHW-1:0] pend,
    output logic [NHW-1:0] en,
    output logic           g,
    output logic           swi_q
);
    for (genvar i = 0; i < NHW; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      f_q <= 1'b0;
            else if (evt[i]) f_q <= 1'b1;
            else if (clr[i]) f_q <= 1'b0;
        end
        assign pend[i] = f_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en <= '0;
        else if (en_wr) en <= en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         g <= 1'b0;
        else if (g_clr_seq) g <= 1'b0;
        else if (g_set_seq) g <= 1'b1;
        else if (g_wr)      g <= g_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        swi_q <= 1'b0;
        else if (swi_req)  swi_q <= 1'b1;
        else if (swi_take) swi_q <= 1'b0;
    end

    p_evt_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));
    p_g_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        g_clr_seq |=> !g);
    p_g_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        g_set_seq |=> g);
    p_swi_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        swi_req |=> swi_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int          PC_W     = 12,
    parameter logic [11:0] VEC_BASE = 12'hFF0,
    parameter int          VEC_STEP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NHW-1:0]  pend,
    input  logic [NHW-1:0]  en,
    input  logic            g,
    input  logic            swi,
    output logic            req_any,
    output logic            win_swi,
    output logic [PC_W-1:0] vec
);
    localparam int IW = $clog2(NSRC);

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;
    logic [IW-1:0]   win;
    logic [IW-1:0]   rank;

    assign req = {swi, pend & en & {NHW{g}}};

    always_comb begin
        win = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i]) win = IW'(i);
        end
    end

    assign req_any = |req;
    assign grant   = req_any ? (NSRC'(1) << win) : '0;
    assign win_swi = grant[IDX_SWI];
    assign rank    = IW'(NSRC - 1) - win;
    assign vec     = PC_W'(VEC_BASE) + PC_W'(VEC_STEP * int'(rank));

    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_hw_needs_g_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_any && !swi) |-> g);
    p_swi_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        swi |-> win_swi);
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_any,
    input  logic            win_swi,
    input  logic [PC_W-1:0] vec_in,
    input  logic            instr_done,
    input  logic            ret_req,
    input  logic            reti_req,
    input  logic [PC_W-1:0] pc_in,
    input  logic [7:0]      stk_rdata,
    output logic            stk_we,
    output logic            stk_re,
    output logic [7:0]      stk_wdata,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_out,
    output logic            busy,
    output logic            g_clr_seq,
    output logic            g_set_seq,
    output logic            swi_take
);
    localparam int HI_W = PC_W - 8;

    seq_state_t      state, nxt;
    logic [PC_W-1:0] pc_hold;
    logic [PC_W-1:0] vec_hold;
    logic [HI_W-1:0] ret_hi;
    logic [7:0]      ret_lo;
    logic            is_reti;
    logic            ret_any;
    logic            accept;

    assign ret_any  = ret_req || reti_req;
    assign accept   = (state == S_IDLE) && !ret_any && req_any && instr_done;
    assign swi_take = accept && win_swi;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (ret_any)     nxt = S_POP_HI;
                else if (accept) nxt = S_PUSH_LO;
            end
            S_PUSH_LO: nxt = S_PUSH_HI;
            S_PUSH_HI: nxt = S_MASK;
            S_MASK:    nxt = S_VECT;
            S_VECT:    nxt = S_LOAD;
            S_LOAD:    nxt = S_IDLE;
            S_POP_HI:  nxt = S_POP_LO;
            S_POP_LO:  nxt = S_RLOAD;
            S_RLOAD:   nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_hold  <= '0;
            vec_hold <= '0;
            ret_hi   <= '0;
            ret_lo   <= '0;
            is_reti  <= 1'b0;
        end else begin
            if (accept) begin
                pc_hold  <= pc_in;
                vec_hold <= vec_in;
            end
            if (state == S_IDLE && ret_any) is_reti <= reti_req;
            if (state == S_POP_HI)          ret_hi  <= stk_rdata[HI_W-1:0];
            if (state == S_POP_LO)          ret_lo  <= stk_rdata;
        end
    end

    always_comb begin
        stk_we    = 1'b0;
        stk_re    = 1'b0;
        stk_wdata = '0;
        pc_load   = 1'b0;
        pc_out    = '0;
        busy      = 1'b1;
        g_clr_seq = 1'b0;
        g_set_seq = 1'b0;
        unique case (state)
            S_IDLE:    busy = 1'b0;
            S_PUSH_LO: begin
                stk_we    = 1'b1;
                stk_wdata = pc_hold[7:0];
            end
            S_PUSH_HI: begin
                stk_we    = 1'b1;
                stk_wdata = 8'(pc_hold[PC_W-1:8]);
            end
            S_MASK:    g_clr_seq = 1'b1;
            S_VECT:    ;
            S_LOAD: begin
                pc_load = 1'b1;
                pc_out  = vec_hold;
            end
            S_POP_HI:  stk_re = 1'b1;
            S_POP_LO:  stk_re = 1'b1;
            S_RLOAD: begin
                pc_load   = 1'b1;
                pc_out    = {ret_hi, ret_lo};
                g_set_seq = is_reti;
            end
            default:   busy = 1'b0;
        endcase
    end

    p_push_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && !$past(stk_we)) |=> stk_we);
    p_pop_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_re && !$past(stk_re)) |=> stk_re);
    p_no_push_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && stk_re));
    p_entry_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && !$past(stk_we)) |-> $past(instr_done));
    p_load_after_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !$past(stk_re)) |-> $past(stk_we, 4));
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_pkg::*;
#(
    parameter int          PC_W     = 12,
    parameter logic [11:0] VEC_BASE = 12'hFF0,
    parameter int          VEC_STEP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      src_evt,
    input  logic [3:0]      src_clr,
    input  logic            en_wr,
    input  logic [3:0]      en_wdata,
    input  logic            g_wr,
    input  logic            g_wdata,
    input  logic            swi_req,
    input  logic            instr_done,
    input  logic            ret_req,
    input  logic            reti_req,
    input  logic [PC_W-1:0] pc_in,
    input  logic [7:0]      stk_rdata,
    output logic            stk_we,
    output logic            stk_re,
    output logic [7:0]      stk_wdata,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_out,
    output logic            busy,
    output logic [3:0]      pend_out,
    output logic [3:0]      en_out,
    output logic            g_out,
    output logic            swi_pending
);
    logic            req_any;
    logic            win_swi;
    logic [PC_W-1:0] vec;
    logic            g_clr_seq;
    logic            g_set_seq;
    logic            swi_take;

    irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (src_evt),
        .clr       (src_clr),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .g_wr      (g_wr),
        .g_wdata   (g_wdata),
        .g_clr_seq (g_clr_seq),
        .g_set_seq (g_set_seq),
        .swi_req   (swi_req),
        .swi_take  (swi_take),
        .pend      (pend_out),
        .en        (en_out),
        .g         (g_out),
        .swi_q     (swi_pending)
    );

    irq_arbiter #(
        .PC_W     (PC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend_out),
        .en      (en_out),
        .g       (g_out),
        .swi     (swi_pending),
        .req_any (req_any),
        .win_swi (win_swi),
        .vec     (vec)
    );

    irq_seq_fsm #(
        .PC_W (PC_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_any    (req_any),
        .win_swi    (win_swi),
        .vec_in     (vec),
        .instr_done (instr_done),
        .ret_req    (ret_req),
        .reti_req   (reti_req),
        .pc_in      (pc_in),
        .stk_rdata  (stk_rdata),
        .stk_we     (stk_we),
        .stk_re     (stk_re),
        .stk_wdata  (stk_wdata),
        .pc_load    (pc_load),
        .pc_out     (pc_out),
        .busy       (busy),
        .g_clr_seq  (g_clr_seq),
        .g_set_seq  (g_set_seq),
        .swi_take   (swi_take)
    );

    p_swi_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_pending && !swi_req && $rose(busy) && !stk_re) |-> !swi_pending || $past(!swi_pending));
endmodule

// File: tb/test_irq_sequencer.sv
`timescale 1ns/1ps
module test_irq_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_evt = '0, src_clr = '0, en_wdata = '0;
    logic        en_wr = 1'b0, g_wr = 1'b0, g_wdata = 1'b0, swi_req = 1'b0;
    logic        instr_done = 1'b0, ret_req = 1'b0, reti_req = 1'b0;
    logic [11:0] pc_in = '0;
    logic [7:0]  stk_rdata;
    logic        stk_we, stk_re, pc_load, busy, g_out, swi_pending;
    logic [7:0]  stk_wdata;
    logic [11:0] pc_out;
    logic [3:0]  pend_out, en_out;

    always #2.5 clk = ~clk;

    irq_sequencer i_irq_sequencer (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_clr(src_clr),
        .en_wr(en_wr), .en_wdata(en_wdata), .g_wr(g_wr), .g_wdata(g_wdata),
        .swi_req(swi_req), .instr_done(instr_done), .ret_req(ret_req),
        .reti_req(reti_req), .pc_in(pc_in), .stk_rdata(stk_rdata),
        .stk_we(stk_we), .stk_re(stk_re), .stk_wdata(stk_wdata),
        .pc_load(pc_load), .pc_out(pc_out), .busy(busy), .pend_out(pend_out),
        .en_out(en_out), .g_out(g_out), .swi_pending(swi_pending)
    );

    // stack model
    logic [7:0] stk_mem [0:15];
    logic [3:0] sp = '0;
    assign stk_rdata = stk_mem[sp - 4'd1];
    always @(posedge clk) begin
        if (stk_we) begin
            stk_mem[sp] <= stk_wdata;
            sp <= sp + 4'd1;
        end else if (stk_re) begin
            sp <= sp - 4'd1;
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int compared = 0, mismatched = 0;
    bit finished = 1'b0;

    typedef struct {
        int    kind;   // 1 push, 2 pc load
        int    data;
        int    due;
        string tag;
    } exp_t;
    exp_t exq[$];

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished && (stk_we || pc_load)) begin
            int k;
            int d;
            k = stk_we ? 1 : 2;
            d = stk_we ? int'(stk_wdata) : int'(pc_out);
            if (exq.size() == 0) begin
                compared++;
                mismatched++;
                $display("FAIL R4: actual unexpected kind %0d data %0h expected none (cycle %0d)", k, d, cyc);
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk({e.tag, " kind"}, k, e.kind);
                chk({e.tag, " data"}, d, e.data);
                chk({e.tag, " cycle"}, cyc, e.due);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(logic [3:0] evt, logic [3:0] clr, logic swi);
        src_evt = evt; src_clr = clr; swi_req = swi;
        tick();
        src_evt = '0; src_clr = '0; swi_req = 1'b0;
    endtask

    task automatic write_en(logic [3:0] v);
        en_wr = 1'b1; en_wdata = v; tick(); en_wr = 1'b0;
    endtask

    task automatic write_g(logic v);
        g_wr = 1'b1; g_wdata = v; tick(); g_wr = 1'b0;
    endtask

    // instr_done with no eligible request: no entry may start
    task automatic idle_try(string tag);
        instr_done = 1'b1; tick(); instr_done = 1'b0;
        chk({tag, " busy after instr_done"}, busy, 0);
        repeat (6) tick();
    endtask

    // R5 R6 R7 R12: entry accepted at cycle k
    task automatic take_irq(string tag, int vec, logic [11:0] pc, logic [3:0] mid);
        int k;
        int bcnt;
        k = cyc;
        bcnt = 0;
        pc_in = pc;
        instr_done = 1'b1;
        exq.push_back('{1, int'(pc[7:0]), k + 1, {tag, " R5 push lo"}});
        exq.push_back('{1, int'({4'h0, pc[11:8]}), k + 2, {tag, " R12 push hi"}});
        exq.push_back('{2, vec, k + 5, {tag, " R7 vector"}});
        tick();
        instr_done = 1'b0;
        for (int j = 1; j <= 5; j++) begin
            if (busy) bcnt++;
            if (j == 4) chk({tag, " R6 G clear at k+4"}, g_out, 0);
            if (j == 2) src_evt = mid;
            tick();
            src_evt = '0;
        end
        chk({tag, " R5 busy cycles"}, bcnt, 5);
        chk({tag, " R5 busy released"}, busy, 0);
    endtask

    // R9 R10: return issued at cycle k
    task automatic do_ret(string tag, logic with_g, logic [11:0] pc, int g_exp);
        int k;
        k = cyc;
        if (with_g) reti_req = 1'b1; else ret_req = 1'b1;
        exq.push_back('{2, int'(pc), k + 3, {tag, " restored pc"}});
        tick();
        reti_req = 1'b0; ret_req = 1'b0;
        repeat (3) tick();
        chk({tag, " G after return"}, g_out, g_exp);
        chk({tag, " busy after return"}, busy, 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("reset busy", busy, 0);
        chk("reset G", g_out, 0);
        chk("reset pend", pend_out, 0);
        chk("reset swi", swi_pending, 0);

        write_en(4'hF);
        drive(4'b0100, 4'b0000, 1'b0);
        chk("R1 timer0 flag set", pend_out, 4'b0100);
        idle_try("R2 G=0 masks");
        chk("R2 flag kept", pend_out, 4'b0100);
        write_en(4'h0);
        write_g(1'b1);
        idle_try("R2 enable off masks");
        write_en(4'hF);
        repeat (4) tick();
        chk("R4 waits for instr_done", busy, 0);

        take_irq("R8 timer0", 12'hFF4, 12'h3A5, 4'b0001);
        chk("R1 R11 flags after entry", pend_out, 4'b0101);
        idle_try("R11 no nesting");
        drive(4'b0100, 4'b0100, 1'b0);
        chk("R1 clear+event same cycle", pend_out, 4'b0101);
        drive(4'b0000, 4'b0100, 1'b0);
        chk("R1 clear", pend_out, 4'b0001);
        do_ret("R9 reti", 1'b1, 12'h3A5, 1);

        drive(4'b1010, 4'b0000, 1'b0);
        chk("R1 multi set", pend_out, 4'b1011);
        take_irq("R8 timer1 over others", 12'hFF2, 12'hABC, 4'b0000);
        drive(4'b0000, 4'b1000, 1'b0);
        do_ret("R9 reti 2", 1'b1, 12'hABC, 1);
        take_irq("R8 wakeup over adc", 12'hFF6, 12'h123, 4'b0000);
        drive(4'b0000, 4'b0010, 1'b0);
        do_ret("R9 reti 3", 1'b1, 12'h123, 1);
        take_irq("R8 adc", 12'hFF8, 12'h456, 4'b0000);
        drive(4'b0000, 4'b0001, 1'b0);
        do_ret("R9 reti 4", 1'b1, 12'h456, 1);
        chk("R1 all clear", pend_out, 0);

        drive(4'b1000, 4'b0000, 1'b1);
        chk("R3 software latched", swi_pending, 1);
        take_irq("R8 software highest", 12'hFF0, 12'h789, 4'b0000);
        chk("R3 software latch dropped", swi_pending, 0);
        do_ret("R9 reti 5", 1'b1, 12'h789, 1);
        take_irq("R11 held timer1", 12'hFF2, 12'h0AA, 4'b0000);
        drive(4'b0000, 4'b1000, 1'b0);
        do_ret("R9 reti 6", 1'b1, 12'h0AA, 1);

        write_g(1'b0);
        drive(4'b0000, 4'b0000, 1'b1);
        take_irq("R3 software with G=0", 12'hFF0, 12'h5F5, 4'b0000);
        do_ret("R10 plain ret", 1'b0, 12'h5F5, 0);

        repeat (4) tick();
        chk("R5 scoreboard drained", exq.size(), 0);
        report();
    end
endmodule